// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This unit builds the interrupt sources of a synchronous serial port and presents them through a small register window. It watches the receive and transmit FIFO fill levels, a one-cycle pulse for each completed received frame, a one-cycle pulse for each receive FIFO read, and a bit-period tick. From these inputs it derives four sources: receive overrun, receive timeout, receive FIFO threshold and transmit FIFO threshold. It drives a single combined interrupt line.

Overrun and timeout are sticky events, and software clears them by writing ones to the clear register. The two threshold sources follow the FIFO levels directly and cannot be cleared by software; they drop only when FIFO traffic changes the level, or they can be masked off. A pending timeout also drops by itself when a new frame arrives. Software reads the raw view to see every condition, the enable register to see which sources may interrupt, and the masked view to find which sources caused the interrupt.

Top module: `serial_irq_unit`

## Requirements
- R1: Reset is synchronous and active low. After reset, both sticky sources, the enable register and `irq` are 0.
- R2: The status bit positions are fixed: bit 0 is overrun, bit 1 is timeout, bit 2 is receive threshold and bit 3 is transmit threshold. Reads of the masked view at `reg_sel`=2 return the raw view ANDed with the enable register. The raw view is read at `reg_sel`=0.
- R3: Overrun becomes 1 on the clock edge that samples `frame_done`=1 while `rx_level` equals DEPTH. A frame received while the FIFO is not full leaves overrun unchanged.
- R4: Raw bit 2 is 1 exactly when `rx_level` >= DEPTH/2.
- R5: Raw bit 3 is 1 exactly when DEPTH - `tx_level` >= DEPTH/2, that is, when at least half of the transmit FIFO is empty.
- R6: A write to `reg_sel`=3 clears overrun on the next edge when data bit 0 is 1, and clears timeout when data bit 1 is 1. A 0 bit has no effect. Bits 2 and 3 in such a write do not change the threshold sources.
- R7: Timeout becomes 1 when `rx_level` is nonzero and `bit_tick` has been sampled 32 times (TIMEOUT_TICKS) with no `frame_done` and no `rx_pop` in between. Any `frame_done` or `rx_pop` restarts the count, and an empty FIFO holds the count at zero.
- R8: A `frame_done` pulse clears a pending timeout on the next edge.
- R9: When a sticky source sees its set event and a clear write in the same cycle, the set wins and the bit reads 1.
- R10: Writes to `reg_sel`=0 and `reg_sel`=2 have no effect. Reads of `reg_sel`=3 return 0.
- R11: `irq` is a register. On each edge it takes the OR of the masked bits that were present before that edge.
- R12: A write to `reg_sel`=1 loads the enable register on the next edge. Reads of `reg_sel`=1 return its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill level, 0..DEPTH |
| tx_level | input | LVL_W | Transmit FIFO fill level, 0..DEPTH |
| frame_done | input | 1 | Pulse: one frame completely received |
| rx_pop | input | 1 | Pulse: software read of the receive FIFO |
| bit_tick | input | 1 | Pulse once per serial bit period |
| reg_sel | input | 2 | Register select: 0 raw, 1 enable, 2 masked, 3 clear |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Register write data |
| rd_data | output | 4 | Register read data for `reg_sel`, combinational |
| irq | output | 1 | Combined registered interrupt |

## Verification
The threshold bits and all register reads settle combinationally within the same cycle. The sticky bits, the enable register and the timeout count change on the first edge after their stimulus, and `irq` follows one edge after the masked bits change. The bench drives its inputs just after a rising edge and passes a single edge for each registered stimulus. It then reads `rd_data` a moment later, before the next edge. It checks `irq` only after one more edge has passed. The timeout is counted tick by tick, so tick 31 still reads 0 and tick 32 reads 1.

// File: rtl/serial_irq_pkg.sv
// Shared definitions for the serial port interrupt unit.
// Assumes a four-source status word whose bit order is fixed.
package serial_irq_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_OVR = 0;   // receive overrun
    localparam int SRC_TMO = 1;   // receive timeout
    localparam int SRC_RXT = 2;   // receive FIFO threshold
    localparam int SRC_TXT = 3;   // transmit FIFO threshold

    typedef enum logic [1:0] {
        SEL_RAW    = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_MASKED = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/sticky_event_flag.sv
// Sticky event bit: set by a one-cycle event and cleared by a request.
// Assumes that a set and a clear in the same cycle must not lose the event.
module sticky_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    assert_clear_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !flag);
    assert_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !clr_req) |=> $stable(flag));
endmodule

// File: rtl/fifo_level_watch.sv
// Level-derived threshold sources for the receive and transmit FIFOs.
// Assumes both levels lie in 0..DEPTH. These outputs are not sticky.
module fifo_level_watch #(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    output logic             rx_half_full,
    output logic             tx_half_empty
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] tx_free;

    // Derive the free slot count and compare both sides against half capacity.
    always_comb begin
        tx_free       = FULL - tx_level;
        rx_half_full  = (rx_level >= HALF);
        tx_half_empty = (tx_free >= HALF);
    end

    assert_rx_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= FULL);
    assert_tx_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= FULL);
endmodule

// File: rtl/rx_idle_timer.sv
// Receive inactivity timer: counts bit ticks while received data waits
// unread. It raises a sticky timeout after LIMIT ticks. Frame arrival or a
// FIFO read restarts the count, and frame arrival also negates the timeout.
module rx_idle_timer #(
    parameter int LIMIT = 32,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_nonempty,
    input  logic frame_done,
    input  logic rx_pop,
    input  logic clr_req,
    output logic timeout
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);

    logic [CNT_W-1:0] idle_cnt;
    logic             activity;
    logic             expire;

    // Classify this cycle's activity and detect the final counted tick.
    always_comb begin
        activity = frame_done | rx_pop;
        expire   = bit_tick & rx_nonempty & !activity & (idle_cnt == LAST);
    end

    // Count ticks of inactivity and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         idle_cnt <= '0;
        else if (activity || !rx_nonempty)  idle_cnt <= '0;
        else if (bit_tick && idle_cnt != TOP) idle_cnt <= idle_cnt + 1'b1;
    end

    sticky_event_flag i_tmo_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire),
        .clr_req (clr_req | frame_done),
        .flag    (timeout)
    );

    assert_restart_on_activity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> (idle_cnt == '0));
    assert_negate_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !timeout);
    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= TOP);
endmodule

// File: rtl/serial_irq_unit.sv
// Interrupt status unit for a synchronous serial port. It combines two
// sticky sources (overrun, timeout) with two FIFO threshold sources and
// exposes raw, enable, masked and clear registers. It drives a registered
// combined interrupt line. Assumes single-cycle pulses on frame_done, rx_pop
// and bit_tick.
module serial_irq_unit #(
    parameter int DEPTH         = 8,
    parameter int TIMEOUT_TICKS = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             frame_done,
    input  logic             rx_pop,
    input  logic             bit_tick,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    output logic [3:0]       rd_data,
    output logic             irq
);
    import serial_irq_pkg::*;

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    src_vec_t raw_vec;
    src_vec_t enable_q;
    src_vec_t masked_vec;
    logic     clr_wr;
    logic     ovr_set;
    logic     ovr_flag;
    logic     tmo_flag;
    logic     rx_thr;
    logic     tx_thr;

    // Decode the clear strobe and the overrun event.
    always_comb begin
        clr_wr  = wr_en && (reg_sel_e'(reg_sel) == SEL_CLEAR);
        ovr_set = frame_done && (rx_level == FULL);
    end

    sticky_event_flag i_ovr_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ovr_set),
        .clr_req (clr_wr & wr_data[SRC_OVR]),
        .flag    (ovr_flag)
    );

    rx_idle_timer #(.LIMIT(TIMEOUT_TICKS)) i_idle_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .rx_nonempty (rx_level != '0),
        .frame_done  (frame_done),
        .rx_pop      (rx_pop),
        .clr_req     (clr_wr & wr_data[SRC_TMO]),
        .timeout     (tmo_flag)
    );

    fifo_level_watch #(.DEPTH(DEPTH)) i_level_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_level      (rx_level),
        .tx_level      (tx_level),
        .rx_half_full  (rx_thr),
        .tx_half_empty (tx_thr)
    );

    // Gather the sources into the raw vector and apply the enable mask.
    always_comb begin
        raw_vec          = '0;
        raw_vec[SRC_OVR] = ovr_flag;
        raw_vec[SRC_TMO] = tmo_flag;
        raw_vec[SRC_RXT] = rx_thr;
        raw_vec[SRC_TXT] = tx_thr;
        masked_vec       = raw_vec & enable_q;
    end

    // Hold the enable register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) enable_q <= '0;
        else if (wr_en && (reg_sel_e'(reg_sel) == SEL_ENABLE)) enable_q <= wr_data;
    end

    // Register the combined interrupt so the output line has no glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |masked_vec;
    end

    // Return the selected register; the clear register reads as zero.
    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_RAW:    rd_data = raw_vec;
            SEL_ENABLE: rd_data = enable_q;
            SEL_MASKED: rd_data = masked_vec;
            SEL_CLEAR:  rd_data = '0;
            default:    rd_data = '0;
        endcase
    end

    assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|masked_vec)));
    assert_enable_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1) |=> (enable_q == $past(wr_data)));
    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == 2'd1) |=> $stable(enable_q));
    assert_ovr_on_full_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_level == FULL) |=> ovr_flag);
endmodule

// File: tb/test_serial_irq_unit.sv
module test_serial_irq_unit;
    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int TICKS = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_level = LVL_W'(DEPTH);
    logic             frame_done = 1'b0;
    logic             rx_pop = 1'b0;
    logic             bit_tick = 1'b0;
    logic [1:0]       reg_sel = 2'd0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_data = '0;
    logic [3:0]       rd_data;
    logic             irq;

    int checks = 0;
    int errors = 0;

    serial_irq_unit #(.DEPTH(DEPTH), .TIMEOUT_TICKS(TICKS)) i_serial_irq_unit (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .frame_done(frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [3:0] val);
        reg_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] val);
        reg_sel = sel; wr_data = val; wr_en = 1'b1;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_frame();
        frame_done = 1'b1; step(); frame_done = 1'b0;
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) step();
        bit_tick = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] v;
        logic [3:0] exp;
        repeat (4) step();
        rst_n = 1'b1;
        // R1: reset state, with rx empty and tx full so no threshold is active
        rd(2'd0, v); check("R1 raw", v, 4'h0);
        rd(2'd1, v); check("R1 enable", v, 4'h0);
        rd(2'd2, v); check("R1 masked", v, 4'h0);
        check("R1 irq", {3'b0, irq}, 4'h0);

        // R12: enable register write and read back
        wr(2'd1, 4'hA); rd(2'd1, v); check("R12 enable", v, 4'hA);
        wr(2'd1, 4'hC); rd(2'd1, v); check("R12 enable", v, 4'hC);

        // R4 R5 R2 R11: exhaustive level sweep with thresholds enabled
        for (int r = 0; r <= DEPTH; r++) begin
            for (int t = 0; t <= DEPTH; t++) begin
                rx_level = LVL_W'(r); tx_level = LVL_W'(t);
                step();
                exp = {4'(((DEPTH - t) >= DEPTH / 2) ? 1 : 0) << 3} |
                      {4'((r >= DEPTH / 2) ? 1 : 0) << 2};
                rd(2'd0, v); check("R4 R5 raw", v, exp);
                rd(2'd2, v); check("R2 masked", v, exp & 4'hC);
                step();
                check("R11 irq", {3'b0, irq}, {3'b0, |(exp & 4'hC)});
            end
        end

        // R10: writes to the raw and masked views are ignored; clear reads 0
        rx_level = '0; tx_level = LVL_W'(DEPTH);
        wr(2'd0, 4'hF); wr(2'd2, 4'hF);
        rd(2'd0, v); check("R10 raw", v, 4'h0);
        rd(2'd1, v); check("R10 enable", v, 4'hC);
        rd(2'd3, v); check("R10 clear read", v, 4'h0);

        // R3: overrun only when the FIFO is full
        rx_level = LVL_W'(DEPTH - 1); pulse_frame();
        rd(2'd0, v); check("R3 not full", v & 4'h1, 4'h0);
        rx_level = LVL_W'(DEPTH); pulse_frame();
        rd(2'd0, v); check("R3 full", v & 4'h1, 4'h1);
        // R6: clear bit 1 leaves overrun set; clear bit 0 clears it
        wr(2'd3, 4'h2); rd(2'd0, v); check("R6 zero bit", v & 4'h1, 4'h1);
        wr(2'd3, 4'h1); rd(2'd0, v); check("R6 clear ovr", v & 4'h1, 4'h0);
        // R6: threshold bits survive a clear write
        tx_level = '0;
        wr(2'd3, 4'hC); rd(2'd0, v); check("R6 thresholds", v & 4'hC, 4'hC);
        tx_level = LVL_W'(DEPTH);

        // R9: set and clear in the same cycle keep the bit set
        frame_done = 1'b1; wr(2'd3, 4'h1); frame_done = 1'b0;
        rd(2'd0, v); check("R9 set wins", v & 4'h1, 4'h1);
        wr(2'd3, 4'h1);

        // R7: timeout after exactly TICKS idle ticks
        rx_level = LVL_W'(2);
        ticks(TICKS - 1); rd(2'd0, v); check("R7 before", v & 4'h2, 4'h0);
        ticks(1);         rd(2'd0, v); check("R7 at limit", v & 4'h2, 4'h2);
        wr(2'd3, 4'h2);   rd(2'd0, v); check("R6 clear tmo", v & 4'h2, 4'h0);
        // R7: a FIFO read restarts the count
        pulse_frame();
        ticks(20);
        rx_pop = 1'b1; step(); rx_pop = 1'b0;
        ticks(TICKS - 1); rd(2'd0, v); check("R7 restart", v & 4'h2, 4'h0);
        ticks(1);         rd(2'd0, v); check("R7 restart limit", v & 4'h2, 4'h2);
        // R8: a received frame negates the pending timeout
        pulse_frame();    rd(2'd0, v); check("R8 negate", v & 4'h2, 4'h0);
        // R7: an empty FIFO never times out
        rx_level = '0;
        ticks(TICKS + 8); rd(2'd0, v); check("R7 empty", v & 4'h2, 4'h0);

        // R2 R11: all sources raised, sweep every enable pattern
        rx_level = LVL_W'(DEPTH); pulse_frame();
        rx_level = LVL_W'(DEPTH / 2); tx_level = LVL_W'(DEPTH / 2);
        ticks(TICKS);
        rd(2'd0, v); check("R2 raw all", v, 4'hF);
        for (int m = 0; m < 16; m++) begin
            wr(2'd1, 4'(m));
            rd(2'd2, v); check("R2 masked sweep", v, 4'(m));
            step();
            check("R11 irq sweep", {3'b0, irq}, {3'b0, (m != 0)});
        end

        // R1: reset again clears sticky bits and enable
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        rd(2'd0, v); check("R1 sticky after reset", v & 4'h3, 4'h0);
        rd(2'd1, v); check("R1 enable after reset", v, 4'h0);
        check("R1 irq after reset", {3'b0, irq}, 4'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule